// File: doc/BRIEF.md
# Three-Wire Latch-Addressed Programming Port

This block accepts a serial word over three slow wires: a serial clock, a data line and a load strobe. It files the word into one of four holding registers that feed a dual frequency synthesizer's dividers. All three wires are brought into the system clock domain through synchronizer flops. Edges of the serial clock are then detected on the synchronized copy. Bits enter a 21-bit shift register, most significant bit first, on each detected rising edge.

When the load strobe rises, the two lowest bits of the shift register are read as an address. The upper 19 bits are copied into the addressed holding register. A one-cycle strobe marks which register changed. The four registers are presented side by side on a flat parallel bus. A readback tap carries the top bit of the shift register and changes only on falling serial clock edges, so an outside observer can sample it on the following rising edge. Turning the held payloads into divider settings is left to downstream logic.

Top module: `serial_latch_port`

## Requirements
- R1: After reset, every holding register reads zero, no update strobe is high and the readback tap is low.
- R2: Each rising edge of the serial clock shifts the data line into bit 0 of the shift register. Earlier bits move toward bit 20, so the first bit sent ends up in bit 20.
- R3: On a load, word bits [1:0] select the destination. Value 0 selects register 0 (bus bits [18:0]), value 1 selects register 1 (bits [37:19]), value 2 selects register 2 (bits [56:38]) and value 3 selects register 3 (bits [75:57]).
- R4: The selected register receives word bits [20:2], with word bit 2 landing in the register's bit 0.
- R5: In the cycle the selected register shows its new value, exactly one update strobe is high, and it is the strobe at the selected index.
- R6: Registers that are not selected keep their previous value across a load.
- R7: Only the first cycle of a load strobe high period performs a transfer. Serial clock edges while the strobe stays high still shift the register, and the shifted word is what the next load transfers.
- R8: The readback tap takes shift register bit 20 on each falling serial clock edge and holds its value at all other times, including across rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock |
| ser_dat_i | input | 1 | Asynchronous serial data, MSB first |
| ser_le_i | input | 1 | Asynchronous load strobe |
| latch_o | output | 76 | Four 19-bit holding registers, register k at bits [19k+18:19k] |
| latch_upd_o | output | 4 | One-cycle update strobe per holding register |
| ser_dout_o | output | 1 | Readback tap of shift register bit 20 |

## Verification
The bench builds the block with its default parameters: a 21-bit word, a 2-bit address giving four registers, and two synchronizer stages. With these values every register index is reachable, and the all-ones and single-bit payloads exercise both ends of the 19-bit field. The serial clock runs at a sixteenth of the system clock, which leaves room to observe the readback tap between the rising and the falling edge. The same default word length lets the bench hold the load strobe high through extra serial edges and predict the three-bit shift that the following load must transfer.

// File: rtl/slp_pkg.sv
`timescale 1ns/1ps
package slp_pkg;
  // Edge events seen on the synchronized serial clock
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/slp_sync.sv
`timescale 1ns/1ps
module slp_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = STAGES * W;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN_W-W-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/slp_shifter.sv
`timescale 1ns/1ps
module slp_shifter
  import slp_pkg::*;
#(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdat,
  input  logic              sle,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o,
  output logic              dout_o
);
  logic       sclk_q;
  logic       le_q;
  sclk_edge_t ev;

  assign ev.rise = sclk & ~sclk_q;
  assign ev.fall = ~sclk & sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      load_o <= 1'b0;
      word_o <= '0;
      dout_o <= 1'b0;
    end else begin
      sclk_q <= sclk;
      le_q   <= sle;
      load_o <= sle & ~le_q;
      if (ev.rise) word_o <= {word_o[WORD_W-2:0], sdat};
      if (ev.fall) dout_o <= word_o[WORD_W-1];
    end
  end

  // R2: a rising edge pulls the data bit into position 0
  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    ev.rise |=> (word_o[0] == $past(sdat)));

  // R8: the readback tap moves only after a falling edge
  a_r8_tap_hold: assert property (@(posedge clk) disable iff (rst)
    !ev.fall |=> $stable(dout_o));
endmodule

// File: rtl/slp_latch_bank.sv
`timescale 1ns/1ps
module slp_latch_bank #(
  parameter int WORD_W = 21,
  parameter int ADDR_W = 2
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      load_i,
  input  logic [WORD_W-1:0]                         word_i,
  output logic [(1<<ADDR_W)*(WORD_W-ADDR_W)-1:0]    latch_o,
  output logic [(1<<ADDR_W)-1:0]                    upd_o
);
  localparam int NUM = 1 << ADDR_W;
  localparam int PAY = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] sel;
  assign sel = word_i[ADDR_W-1:0];

  for (genvar i = 0; i < NUM; i++) begin : g_lat
    logic           hit;
    logic [PAY-1:0] held;
    logic           strobe;

    assign hit = load_i && (sel == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        held   <= '0;
        strobe <= 1'b0;
      end else begin
        strobe <= hit;
        if (hit) held <= word_i[WORD_W-1:ADDR_W];
      end
    end

    assign latch_o[i*PAY +: PAY] = held;
    assign upd_o[i]              = strobe;

    // R6: a register without its strobe has not changed
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      !upd_o[i] |-> $stable(latch_o[i*PAY +: PAY]));
  end

  // R5: never more than one strobe at once
  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_o));

  // R7: a transfer is never followed by another in the next cycle
  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    (|upd_o) |=> !(|upd_o));
endmodule

// File: rtl/serial_latch_port.sv
`timescale 1ns/1ps
module serial_latch_port #(
  parameter int WORD_W      = 21,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   ser_clk_i,
  input  logic                                   ser_dat_i,
  input  logic                                   ser_le_i,
  output logic [(1<<ADDR_W)*(WORD_W-ADDR_W)-1:0] latch_o,
  output logic [(1<<ADDR_W)-1:0]                 latch_upd_o,
  output logic                                   ser_dout_o
);
  localparam int NUM = 1 << ADDR_W;

  logic [2:0]        raw_in;
  logic [2:0]        syn_in;
  logic [WORD_W-1:0] word;
  logic              load;

  assign raw_in = {ser_le_i, ser_dat_i, ser_clk_i};

  slp_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  slp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .sclk   (syn_in[0]),
    .sdat   (syn_in[1]),
    .sle    (syn_in[2]),
    .word_o (word),
    .load_o (load),
    .dout_o (ser_dout_o)
  );

  slp_latch_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .word_i  (word),
    .latch_o (latch_o),
    .upd_o   (latch_upd_o)
  );

  // R1: out of reset nothing is flagged as updated
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (latch_upd_o == NUM'(0)));
endmodule

// File: tb/sim_serial_latch_port.sv
`timescale 1ns/1ps
module sim_serial_latch_port;
  localparam int WW  = 21;
  localparam int AW  = 2;
  localparam int NL  = 4;
  localparam int PW  = 19;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [NL*PW-1:0] latch;
  logic [NL-1:0]    upd;
  logic             dout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int            idx;
    logic [PW-1:0] pay;
  } exp_t;

  exp_t          q_exp[$];
  logic [PW-1:0] model[NL];

  always #2.5 clk = ~clk;

  serial_latch_port u0 (
    .clk         (clk),
    .rst         (rst),
    .ser_clk_i   (sclk),
    .ser_dat_i   (sdat),
    .ser_le_i    (sle),
    .latch_o     (latch),
    .latch_upd_o (upd),
    .ser_dout_o  (dout)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b);
    sdat = b;
    wait_n(HALF);
    sclk = 1'b1;
    wait_n(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_word(logic [WW-1:0] w);
    for (int i = WW - 1; i >= 0; i--) shift_bit(w[i]);
    wait_n(HALF);
  endtask

  task automatic expect_load(logic [WW-1:0] w);
    exp_t e;
    e.idx = int'(w[AW-1:0]);
    e.pay = w[WW-1:AW];
    q_exp.push_back(e);
    model[e.idx] = e.pay;
  endtask

  task automatic pulse_le(logic [WW-1:0] w);
    expect_load(w);
    sle = 1'b1;
    wait_n(HALF);
    sle = 1'b0;
    wait_n(HALF);
  endtask

  task automatic verify_all(string req);
    for (int i = 0; i < NL; i++)
      check(req, 32'(latch[i*PW +: PW]), 32'(model[i]));
  endtask

  // Monitor: pops one expected transfer for every strobe seen (R3 R4 R5 R7)
  always @(negedge clk) begin
    if (!rst && upd != '0) begin
      if (q_exp.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R7 unexpected strobe actual=%0h expected=0", upd);
      end else begin
        exp_t e;
        e = q_exp.pop_front();
        check("R5 R3 strobe index", 32'(upd), 32'(1) << e.idx);
        check("R4 payload", 32'(latch[e.idx*PW +: PW]), 32'(e.pay));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] w0, w1, w2, w3, w4, w5, ws;
    for (int i = 0; i < NL; i++) model[i] = '0;
    wait_n(10);
    rst = 1'b0;
    wait_n(4);

    // R1 reset state
    verify_all("R1 reset latch");
    check("R1 reset strobe", 32'(upd), 32'h0);
    check("R1 reset tap", 32'(dout), 32'h0);

    w0 = {19'h5A3C1, 2'd0};
    w1 = {19'h7FFFF, 2'd1};
    w2 = {19'h00001, 2'd2};
    w3 = {19'h40000, 2'd3};
    w4 = {19'h12345, 2'd0};
    w5 = {19'h2AAAA, 2'd2};

    // R2 R8: first bit sent is the tap after the last falling edge
    send_word(w0);
    check("R8 R2 tap after word", 32'(dout), 32'(w0[WW-1]));
    pulse_le(w0);
    verify_all("R3 R4 R6 latch0");

    // R8: tap holds across a rising edge, moves on the falling edge
    sdat = 1'b0;
    wait_n(HALF);
    sclk = 1'b1;
    wait_n(HALF);
    check("R8 tap held over rise", 32'(dout), 32'(w0[WW-1]));
    sclk = 1'b0;
    wait_n(HALF);
    check("R8 tap after fall", 32'(dout), 32'(w0[WW-2]));

    send_word(w1); pulse_le(w1); verify_all("R3 R6 latch1");
    send_word(w2); pulse_le(w2); verify_all("R3 R6 latch2");
    send_word(w3); pulse_le(w3); verify_all("R3 R6 latch3");
    send_word(w4); pulse_le(w4); verify_all("R6 overwrite latch0");

    // R7: strobe held high while clocking three more bits
    send_word(w5);
    expect_load(w5);
    sle = 1'b1;
    wait_n(HALF);
    shift_bit(1'b0);
    shift_bit(1'b1);
    shift_bit(1'b1);
    wait_n(HALF);
    sle = 1'b0;
    wait_n(2 * HALF);
    verify_all("R7 single transfer");
    ws = {w5[WW-4:0], 3'b011};
    pulse_le(ws);
    verify_all("R7 shifted word loaded");
    check("R7 queue drained", 32'(q_exp.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule